// File: doc/BRIEF.md
# Segmented Driver Slice Enable Controller

This block produces the static control word for a transmitter output stage made of identical parallel driver slices. Each slice holds several binary-weighted subslices. A slice-count code sets how many slices drive the line, and so the output impedance. Slices are switched on from index 0 upward, and every other slice is put in tri-state through its data path.

Within the enabled set, any slice can be margined. A margined slice is held at a static pull-up or a static pull-down level and no longer switches with data. Margining leaves the enabled count untouched, so it changes the swing and never the impedance. A margining request aimed at a slice that is switched off is dropped. The block reports how many enabled slices carry data and how many are held static.

The control settings are loaded in one step when the update strobe is sampled high. The outputs therefore never show a partial configuration.

Top module: `slc_ctrl`

## Requirements
- R1: After a synchronous active-low reset, slices 0 to 17 are enabled in dynamic mode, the remaining slices are off, `dyn_cnt_o` is 18 and `stat_cnt_o` is 0.
- R2: On a clock edge where `upd_i` is high, a count N in 0..22 takes effect on that edge: slices 0 to N-1 are enabled and all others are disabled.
- R3: A count above the slice total (22) saturates, so all 22 slices are enabled.
- R4: An enabled slice whose request bit is set takes mode 2'b01 (static pull-up) when its level bit is 1, and mode 2'b10 (static pull-down) when its level bit is 0. Slice i uses `mode_o[2*i+1:2*i]`.
- R5: A margining request on a disabled slice is ignored. That slice keeps mode 2'b11 (off) and its enable at 0, and the request is not counted.
- R6: Margining never changes which slices are enabled. For a given count, the enable vector is the same whatever the request bits are.
- R7: `stat_cnt_o` equals the number of margining requests actually applied. `dyn_cnt_o` plus `stat_cnt_o` equals the number of enabled slices.
- R8: While `upd_i` is low, all outputs hold their values, whatever the other inputs do.
- R9: Every subslice enable of slice i, `sub_en_o[5*i+4:5*i]`, equals the enable of slice i.
- R10: An enabled slice with no request is in mode 2'b00 (dynamic data).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_i | input | 1 | Update strobe; loads the new settings |
| cnt_i | input | 5 | Requested enabled-slice count (saturates at 22) |
| marg_req_i | input | 22 | Per-slice margining request |
| marg_lvl_i | input | 22 | Per-slice static level: 1 for pull-up, 0 for pull-down |
| slice_en_o | output | 22 | Per-slice enable; 0 means tri-state |
| sub_en_o | output | 110 | Per-subslice enable, 5 per slice |
| mode_o | output | 44 | Per-slice mode, 2 bits each |
| dyn_cnt_o | output | 5 | Number of enabled slices carrying data |
| stat_cnt_o | output | 5 | Number of enabled slices held static |

## Verification
The bench builds the block with its default values: 22 slices, 5 subslices and a reset count of 18. With a 5-bit count code, random codes range up to 31, so the saturation region above 22 is exercised often. Random request and level masks land on both enabled and disabled slices, so dropped requests and applied requests are mixed in every update. Directed cases cover a count of 0, a full count, margining on disabled slices only, and changes to the inputs with the strobe low.

// File: rtl/slc_pkg.sv
// Shared types for the slice enable controller.
// Assumes a 2-bit per-slice mode code that the driver decodes.
package slc_pkg;
    typedef enum logic [1:0] {
        SM_DYN = 2'b00,   // switches with data
        SM_HI  = 2'b01,   // static pull-up
        SM_LO  = 2'b10,   // static pull-down
        SM_OFF = 2'b11    // slice tri-stated
    } slc_mode_e;
endpackage

// File: rtl/slc_therm.sv
// Saturating count to thermometer enable vector.
// Assumes CW bits can hold N. Slices are filled from index 0 upward.
module slc_therm #(
    parameter int N  = 22,
    parameter int CW = 5
) (
    input  logic [CW-1:0] cnt_i,
    output logic [N-1:0]  en_o,
    output logic [CW-1:0] sat_o
);
    localparam logic [CW-1:0] MAXC = CW'(N);

    // Clamp the request to the slice total
    always_comb sat_o = (cnt_i > MAXC) ? MAXC : cnt_i;

    for (genvar g = 0; g < N; g++) begin : g_en
        assign en_o[g] = (sat_o > CW'(g));
    end
endmodule

// File: rtl/slc_mode_cell.sv
// Mode select for one slice.
// Assumes the enable comes from the thermometer decode. A request on a disabled slice is dropped.
module slc_mode_cell
    import slc_pkg::*;
(
    input  logic       en_i,
    input  logic       req_i,
    input  logic       lvl_i,
    output logic [1:0] mode_o,
    output logic       applied_o
);
    slc_mode_e m;

    // Pick the mode from the enable, the request and the level
    always_comb begin
        if (!en_i)      m = SM_OFF;
        else if (req_i) m = lvl_i ? SM_HI : SM_LO;
        else            m = SM_DYN;
    end

    assign mode_o    = m;
    assign applied_o = en_i & req_i;
endmodule

// File: rtl/slc_popcnt.sv
// Population count of a vector.
// Assumes CW bits can hold N.
module slc_popcnt #(
    parameter int N  = 22,
    parameter int CW = 5
) (
    input  logic [N-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    // Sum the set bits
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < N; i++) cnt_o = cnt_o + CW'(vec_i[i]);
    end
endmodule

// File: rtl/slc_ctrl.sv
// Top level: slice enable and margining controller.
// Computes the next state from the inputs and loads all of it in one
// step on the update strobe. Assumes the strobe is synchronous to clk.
module slc_ctrl #(
    parameter int NSLICE  = 22,
    parameter int NSUB    = 5,
    parameter int DEF_CNT = 18,
    localparam int CW     = $clog2(NSLICE + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_i,
    input  logic [CW-1:0]        cnt_i,
    input  logic [NSLICE-1:0]    marg_req_i,
    input  logic [NSLICE-1:0]    marg_lvl_i,
    output logic [NSLICE-1:0]    slice_en_o,
    output logic [NSLICE*NSUB-1:0] sub_en_o,
    output logic [2*NSLICE-1:0]  mode_o,
    output logic [CW-1:0]        dyn_cnt_o,
    output logic [CW-1:0]        stat_cnt_o
);
    import slc_pkg::*;

    function automatic logic [NSLICE-1:0] rst_en();
        logic [NSLICE-1:0] v;
        for (int i = 0; i < NSLICE; i++) v[i] = (i < DEF_CNT);
        return v;
    endfunction

    function automatic logic [2*NSLICE-1:0] rst_mode();
        logic [2*NSLICE-1:0] v;
        for (int i = 0; i < NSLICE; i++) v[2*i +: 2] = (i < DEF_CNT) ? SM_DYN : SM_OFF;
        return v;
    endfunction

    localparam logic [NSLICE-1:0]   RST_EN   = rst_en();
    localparam logic [2*NSLICE-1:0] RST_MODE = rst_mode();

    logic [NSLICE-1:0]   en_d;
    logic [CW-1:0]       sat_d;
    logic [2*NSLICE-1:0] mode_d;
    logic [NSLICE-1:0]   appl_d;
    logic [CW-1:0]       stat_d;

    slc_therm #(.N(NSLICE), .CW(CW)) u_therm (
        .cnt_i (cnt_i),
        .en_o  (en_d),
        .sat_o (sat_d)
    );

    for (genvar g = 0; g < NSLICE; g++) begin : g_cell
        slc_mode_cell u_cell (
            .en_i      (en_d[g]),
            .req_i     (marg_req_i[g]),
            .lvl_i     (marg_lvl_i[g]),
            .mode_o    (mode_d[2*g +: 2]),
            .applied_o (appl_d[g])
        );
    end

    slc_popcnt #(.N(NSLICE), .CW(CW)) u_pop (
        .vec_i (appl_d),
        .cnt_o (stat_d)
    );

    // Load every setting together on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slice_en_o <= RST_EN;
            mode_o     <= RST_MODE;
            dyn_cnt_o  <= CW'(DEF_CNT);
            stat_cnt_o <= '0;
        end else if (upd_i) begin
            slice_en_o <= en_d;
            mode_o     <= mode_d;
            dyn_cnt_o  <= sat_d - stat_d;
            stat_cnt_o <= stat_d;
        end
    end

    for (genvar g = 0; g < NSLICE; g++) begin : g_sub
        assign sub_en_o[g*NSUB +: NSUB] = {NSUB{slice_en_o[g]}};
    end
endmodule

// File: rtl/slc_ctrl_chk.sv
// Checker for slc_ctrl. It watches the ports only and is attached through bind.
module slc_ctrl_chk #(
    parameter int NSLICE = 22,
    parameter int NSUB   = 5,
    parameter int CW     = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   upd_i,
    input logic [NSLICE-1:0]      slice_en_o,
    input logic [NSLICE*NSUB-1:0] sub_en_o,
    input logic [2*NSLICE-1:0]    mode_o,
    input logic [CW-1:0]          dyn_cnt_o,
    input logic [CW-1:0]          stat_cnt_o
);
    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> ($stable(slice_en_o) && $stable(mode_o) && $stable(dyn_cnt_o) && $stable(stat_cnt_o)));

    // R7
    count_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(dyn_cnt_o) + 32'(stat_cnt_o)) == 32'($countones(slice_en_o)));

    // R2
    contiguous_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((slice_en_o & (slice_en_o + 1'b1)) == '0));

    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        // R5
        off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !slice_en_o[g] |-> (mode_o[2*g +: 2] == 2'b11));
        // R9
        sub_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sub_en_o[g*NSUB +: NSUB] == {NSUB{slice_en_o[g]}});
    end
endmodule

bind slc_ctrl slc_ctrl_chk #(.NSLICE(NSLICE), .NSUB(NSUB), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_i      (upd_i),
    .slice_en_o (slice_en_o),
    .sub_en_o   (sub_en_o),
    .mode_o     (mode_o),
    .dyn_cnt_o  (dyn_cnt_o),
    .stat_cnt_o (stat_cnt_o)
);

// File: tb/slc_ctrl_test.sv
// Self-checking bench for slc_ctrl: directed corners plus seeded random updates.
module slc_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 22;
    localparam int S  = 5;
    localparam int CW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd = 1'b0;
    logic [CW-1:0] cnt = '0;
    logic [N-1:0] req = '0, lvl = '0;
    logic [N-1:0] en;
    logic [N*S-1:0] sub;
    logic [2*N-1:0] mode;
    logic [CW-1:0] dync, statc;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .upd_i(upd), .cnt_i(cnt),
        .marg_req_i(req), .marg_lvl_i(lvl),
        .slice_en_o(en), .sub_en_o(sub), .mode_o(mode),
        .dyn_cnt_o(dync), .stat_cnt_o(statc)
    );

    function automatic int sat(int c);
        return (c > N) ? N : c;
    endfunction

    function automatic logic [N-1:0] x_en(int c);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (i < sat(c));
        return v;
    endfunction

    function automatic logic [2*N-1:0] x_mode(int c, logic [N-1:0] r, logic [N-1:0] l);
        logic [2*N-1:0] v;
        for (int i = 0; i < N; i++) begin
            if (i >= sat(c))  v[2*i +: 2] = 2'b11;
            else if (r[i])    v[2*i +: 2] = l[i] ? 2'b01 : 2'b10;
            else              v[2*i +: 2] = 2'b00;
        end
        return v;
    endfunction

    function automatic int x_stat(int c, logic [N-1:0] r);
        int k = 0;
        for (int i = 0; i < sat(c); i++) k += int'(r[i]);
        return k;
    endfunction

    function automatic logic [N*S-1:0] x_sub(logic [N-1:0] e);
        logic [N*S-1:0] v;
        for (int i = 0; i < N; i++) v[i*S +: S] = {S{e[i]}};
        return v;
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare all outputs with the values computed for count c and masks r, l
    task automatic chk_all(string tag, int c, logic [N-1:0] r, logic [N-1:0] l);
        chk({tag, " en R2/R3/R6"}, 128'(en), 128'(x_en(c)));
        chk({tag, " mode R4/R5/R10"}, 128'(mode), 128'(x_mode(c, r, l)));
        chk({tag, " stat R7"}, 128'(statc), 128'(x_stat(c, r)));
        chk({tag, " dyn R7"}, 128'(dync), 128'(sat(c) - x_stat(c, r)));
        chk({tag, " sub R9"}, 128'(sub), 128'(x_sub(x_en(c))));
    endtask

    // Drive one update and check on the following negedge
    task automatic apply(string tag, int c, logic [N-1:0] r, logic [N-1:0] l);
        @(negedge clk);
        cnt = CW'(c); req = r; lvl = l; upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        chk_all(tag, c, r, l);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7919));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_all("R1 reset", 18, '0, '0);

        apply("R2 count0", 0, '1, '1);
        apply("R2 count22", 22, '0, '0);
        apply("R3 count31", 31, '0, '0);
        apply("R3 count23", 23, 22'h155555, 22'h0F0F0F);
        apply("R4 all hi", 18, '1, '1);
        apply("R4 all lo", 18, '1, '0);
        // R5: requests only on disabled slices
        apply("R5 off req", 4, 22'h3FFFF0, 22'h2AAAA0);
        // R6: same count, different margining
        apply("R6 nomarg", 10, '0, '0);
        apply("R6 marg", 10, 22'h0003FF, 22'h000155);

        // R8: change inputs without strobe, outputs keep the last update
        @(negedge clk);
        cnt = 5'd3; req = '1; lvl = '0;
        repeat (3) @(negedge clk);
        chk_all("R8 hold", 10, 22'h0003FF, 22'h000155);

        for (int k = 0; k < 400; k++) begin
            int c = int'($urandom_range(0, 31));
            logic [N-1:0] r = N'($urandom);
            logic [N-1:0] l = N'($urandom);
            apply("rand", c, r, l);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule